// File: doc/BRIEF.md
# Lockstep Core Comparator with Self-Test

This block watches the output buses of two redundant processor cores that execute the same program in step. Each clock cycle it compares the two buses and, in the normal mode, reports any difference as a one-cycle pulse on a compare-error output and in a sticky status flag. Software uses it as the detection point for divergence between the two cores.

Software selects the operating mode by writing a key code into a key register over a small register port. There are four modes. Normal compare checks the cores. Self-test drives a built-in walking-one, walking-zero and deliberate-mismatch sequence through the comparator. Compare-error forcing proves the compare-error path. Self-test-error forcing proves the self-test-error path. Both forcing modes fire once and then put the key back to normal compare without a software write.

Register writes count only when the privilege qualifier is high. Once the debug-halt input has been seen, the block stops reporting errors, freezes its status and ignores writes until the next reset.

Top module: `lockstep_cmp_top`

## Requirements
- R1: With key 0x0, a difference in any bit between `core_a` and `core_b` at a rising edge makes `cmp_err` high for the following cycle and sets status bit 0 (compare flag). Equal buses give no pulse.
- R2: `cmp_err` is high for exactly one cycle per mismatching sample, so consecutive mismatching cycles give consecutive pulses. Status bit 0 stays set after the buses agree again.
- R3: Writing key 0x6 starts a self-test of 2*W+1 cycles. Status bit 1 (self-test done) reads 1 from the (2*W+1)th rising edge after the write edge and reads 0 before that. While the self-test runs, the core buses are not compared and `cmp_err` stays low.
- R4: A completed self-test on a healthy block leaves status bit 0 set, because of its deliberate-mismatch step, and does not pulse `st_err`.
- R5: Status bit 1 reads 0 whenever the key is not 0x6, even after a self-test has completed.
- R6: Writing key 0x9 pulses `cmp_err` for one cycle and sets status bit 0, with equal core buses. On the same edge that makes the pulse, the key returns to 0x0.
- R7: Writing key 0xF pulses `st_err` for one cycle, leaves `cmp_err` low and status bit 0 unchanged, and returns the key to 0x0. Normal compare then resumes.
- R8: A register write made while `priv` is 0 changes neither the key nor the status.
- R9: From the first cycle `dbg_halt` is high until the next reset, both error outputs stay low, the status does not change and register writes are ignored, even after `dbg_halt` falls.
- R10: A key write with a value other than 0x0, 0x6, 0x9 or 0xF is ignored, and the key keeps its value.
- R11: Status bits are write-one-to-clear at address 0. Writing a 0 to a bit leaves it unchanged.
- R12: After reset, the key reads 0x0, the status reads 0 and both error outputs are low.

Register map: address 0 is status (bit 0 compare flag, bit 1 self-test done). Address 1 is the key in bits 3:0. Reads are combinational from `reg_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_a | input | W | Output bus of the first core |
| core_b | input | W | Output bus of the second core |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 status, 1 key |
| reg_wdata | input | 4 | Register write data |
| reg_rdata | output | 4 | Register read data for `reg_addr` |
| priv | input | 1 | High when the writer is privileged |
| dbg_halt | input | 1 | Debug halt of the cores |
| cmp_err | output | 1 | Compare-error pulse |
| st_err | output | 1 | Self-test-error pulse |

## Verification
The compare is tried with equal buses, a single flipped top bit, a single flipped bottom bit held for two cycles, and a multi-bit difference presented during self-test. These show that detection works at both ends of the bus, that each mismatching cycle gives its own pulse, and that the self-test mode does not look at the cores. Each forcing key is run with equal buses, so a pulse can only come from the forcing path. Both pins are checked on that cycle, which tells the two forcing paths apart. Privilege, unknown-key and debug-halt cases each attempt a change that would be visible on the key readback, the status readback or the pins, so that an ignored write can be told apart from an accepted one.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

    localparam int KEY_W  = 4;
    localparam int DATA_W = 4;

    typedef enum logic [KEY_W-1:0] {
        MODE_LOCK = 4'h0,
        MODE_SELF = 4'h6,
        MODE_FCMP = 4'h9,
        MODE_FST  = 4'hF
    } lsc_mode_e;

    typedef enum logic {
        ADDR_STAT = 1'b0,
        ADDR_KEY  = 1'b1
    } lsc_addr_e;

    typedef struct packed {
        logic stc;
        logic cmpf;
    } lsc_status_t;

    function automatic logic key_known(input logic [KEY_W-1:0] k);
        return (k == MODE_LOCK) || (k == MODE_SELF) ||
               (k == MODE_FCMP) || (k == MODE_FST);
    endfunction

endpackage

// File: rtl/lsc_compare.sv
module lsc_compare #(
    parameter int W      = 32,
    parameter int LANE_W = 8
) (
    input  logic [W-1:0] core_a,
    input  logic [W-1:0] core_b,
    input  logic [W-1:0] pat_a,
    input  logic [W-1:0] pat_b,
    input  logic         use_pat,
    output logic         mismatch
);
    localparam int NL    = (W + LANE_W - 1) / LANE_W;
    localparam int PAD_W = NL * LANE_W;

    logic [W-1:0]     sel_a, sel_b;
    logic [PAD_W-1:0] ext_a, ext_b;
    logic [NL-1:0]    lane_diff;

    always_comb begin
        sel_a = use_pat ? pat_a : core_a;
        sel_b = use_pat ? pat_b : core_b;
        ext_a = PAD_W'(sel_a);
        ext_b = PAD_W'(sel_b);
    end

    for (genvar gi = 0; gi < NL; gi++) begin : g_lane
        assign lane_diff[gi] = |(ext_a[gi*LANE_W +: LANE_W] ^ ext_b[gi*LANE_W +: LANE_W]);
    end

    assign mismatch = |lane_diff;

endmodule

// File: rtl/lsc_selftest.sv
module lsc_selftest #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         abort,
    input  logic         run_en,
    input  logic         mismatch,
    output logic [W-1:0] pat_a,
    output logic [W-1:0] pat_b,
    output logic         done,
    output logic         fail,
    output logic         check_hit
);
    localparam int ST_LEN = 2 * W + 1;
    localparam int CNT_W  = $clog2(ST_LEN + 1);
    localparam logic [CNT_W-1:0] PH_ZERO = CNT_W'(W);
    localparam logic [CNT_W-1:0] PH_CHK  = CNT_W'(2 * W);
    localparam logic [W-1:0]     ONE_HOT = {{(W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt;
    logic             active_q;
    logic             err_q;
    logic             expect_mis;
    logic             last, step, bad;

    always_comb begin
        expect_mis = 1'b0;
        if (cnt < PH_ZERO) begin
            pat_a = ONE_HOT << cnt;
            pat_b = pat_a;
        end else if (cnt < PH_CHK) begin
            pat_a = ~(ONE_HOT << (cnt - PH_ZERO));
            pat_b = pat_a;
        end else begin
            pat_a      = '0;
            pat_b      = ONE_HOT;
            expect_mis = 1'b1;
        end
    end

    assign last      = (cnt == PH_CHK);
    assign step      = active_q && run_en;
    assign bad       = step && (mismatch != expect_mis);
    assign done      = step && last;
    assign fail      = done && (err_q || bad);
    assign check_hit = done && mismatch;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            cnt      <= '0;
            err_q    <= 1'b0;
        end else if (start) begin
            active_q <= 1'b1;
            cnt      <= '0;
            err_q    <= 1'b0;
        end else if (abort) begin
            active_q <= 1'b0;
        end else if (step) begin
            err_q <= err_q | bad;
            if (last) active_q <= 1'b0;
            else      cnt      <= cnt + 1'b1;
        end
    end

    // R3: the sequence ends after its single completion cycle
    a_r3_single_done: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> !active_q);

endmodule

// File: rtl/lsc_regs.sv
module lsc_regs
    import lsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              priv,
    input  logic              dbg_halt,
    input  logic              set_cmpf,
    input  logic              set_stc,
    output lsc_mode_e         mode,
    output logic              halted,
    output logic              st_start,
    output logic [DATA_W-1:0] reg_rdata
);
    lsc_status_t status_q;
    logic        frozen_q;
    logic        wr_ok, key_we, stat_we;

    assign halted   = frozen_q | dbg_halt;
    assign wr_ok    = reg_wr && priv && !halted;
    assign key_we   = wr_ok && (reg_addr == ADDR_KEY) && key_known(reg_wdata);
    assign stat_we  = wr_ok && (reg_addr == ADDR_STAT);
    assign st_start = key_we && (reg_wdata == MODE_SELF);

    always_ff @(posedge clk) begin
        if (rst) frozen_q <= 1'b0;
        else     frozen_q <= frozen_q | dbg_halt;
    end

    always_ff @(posedge clk) begin
        if (rst)
            mode <= MODE_LOCK;
        else if (key_we)
            mode <= lsc_mode_e'(reg_wdata);
        else if (!halted && (mode == MODE_FCMP || mode == MODE_FST))
            mode <= MODE_LOCK;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
        end else if (!halted) begin
            status_q.cmpf <= set_cmpf | (status_q.cmpf & ~(stat_we & reg_wdata[0]));
            status_q.stc  <= set_stc  | (status_q.stc  & ~(stat_we & reg_wdata[1]) & ~st_start);
        end
    end

    always_comb begin
        if (reg_addr == ADDR_KEY)
            reg_rdata = mode;
        else
            reg_rdata = {2'b00, status_q.stc & (mode == MODE_SELF), status_q.cmpf};
    end

    // R6/R7: a forcing key falls back to normal compare on its own
    a_r6_force_returns: assert property (@(posedge clk) disable iff (rst)
        ((mode == MODE_FCMP || mode == MODE_FST) && !halted && !key_we) |=> (mode == MODE_LOCK));

    // R8: an unprivileged write leaves a settled key untouched
    a_r8_user_key_kept: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !priv && (mode == MODE_LOCK || mode == MODE_SELF)) |=> $stable(mode));

    // R9: status frozen while halted
    a_r9_status_frozen: assert property (@(posedge clk) disable iff (rst)
        halted |=> $stable(status_q));

    // R4: completion of the self-test coincides with the compare flag
    a_r4_done_with_flag: assert property (@(posedge clk) disable iff (rst)
        $rose(status_q.stc) |-> status_q.cmpf);

endmodule

// File: rtl/lockstep_cmp_top.sv
module lockstep_cmp_top
    import lsc_pkg::*;
#(
    parameter int W      = 32,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [W-1:0]      core_a,
    input  logic [W-1:0]      core_b,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              priv,
    input  logic              dbg_halt,
    output logic              cmp_err,
    output logic              st_err
);
    lsc_mode_e    mode;
    logic         halted, st_start;
    logic [W-1:0] pat_a, pat_b;
    logic         mismatch;
    logic         st_done, st_fail, st_check_hit;
    logic         lock_evt, fcmp_evt, fst_evt;
    logic         in_self;

    assign in_self  = (mode == MODE_SELF);
    assign lock_evt = (mode == MODE_LOCK) && mismatch && !halted;
    assign fcmp_evt = (mode == MODE_FCMP) && !halted;
    assign fst_evt  = (mode == MODE_FST)  && !halted;

    lsc_regs i_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .priv      (priv),
        .dbg_halt  (dbg_halt),
        .set_cmpf  (lock_evt | fcmp_evt | st_check_hit),
        .set_stc   (st_done),
        .mode      (mode),
        .halted    (halted),
        .st_start  (st_start),
        .reg_rdata (reg_rdata)
    );

    lsc_selftest #(.W(W)) i_selftest (
        .clk       (clk),
        .rst       (rst),
        .start     (st_start),
        .abort     (!in_self),
        .run_en    (in_self && !halted),
        .mismatch  (mismatch),
        .pat_a     (pat_a),
        .pat_b     (pat_b),
        .done      (st_done),
        .fail      (st_fail),
        .check_hit (st_check_hit)
    );

    lsc_compare #(.W(W), .LANE_W(LANE_W)) i_compare (
        .core_a   (core_a),
        .core_b   (core_b),
        .pat_a    (pat_a),
        .pat_b    (pat_b),
        .use_pat  (in_self),
        .mismatch (mismatch)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_err <= 1'b0;
            st_err  <= 1'b0;
        end else begin
            cmp_err <= lock_evt | fcmp_evt;
            st_err  <= fst_evt | st_fail;
        end
    end

    // R1: a differing sample in normal compare gives the pulse
    a_r1_lock_pulse: assert property (@(posedge clk) disable iff (rst)
        ((mode == MODE_LOCK) && (core_a != core_b) && !halted) |=> cmp_err);

    // R9: no error reported while halted
    a_r9_quiet_halt: assert property (@(posedge clk) disable iff (rst)
        halted |=> (!cmp_err && !st_err));

    // R7: self-test-error forcing never touches the compare path
    a_r7_fst_no_cmp: assert property (@(posedge clk) disable iff (rst)
        ((mode == MODE_FST) && !halted) |=> !cmp_err);

    // R3: cores ignored during self-test
    a_r3_self_no_cmp: assert property (@(posedge clk) disable iff (rst)
        in_self |=> !cmp_err);

endmodule

// File: tb/test_lockstep_cmp_top.sv
module test_lockstep_cmp_top;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] core_a = '0;
    logic [W-1:0] core_b = '0;
    logic         reg_wr = 1'b0;
    logic         reg_addr = 1'b0;
    logic [3:0]   reg_wdata = '0;
    logic [3:0]   reg_rdata;
    logic         priv = 1'b1;
    logic         dbg_halt = 1'b0;
    logic         cmp_err, st_err;

    always #2 clk = ~clk;

    lockstep_cmp_top #(.W(W)) i_lockstep_cmp_top (
        .clk(clk), .rst(rst), .core_a(core_a), .core_b(core_b),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .priv(priv), .dbg_halt(dbg_halt),
        .cmp_err(cmp_err), .st_err(st_err)
    );

    typedef struct {
        bit         on_pins;
        logic [3:0] exp;
        string      tag;
    } item_t;

    item_t sbq[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    finished = 1'b0;

    // monitor: pops every queued expectation at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (sbq.size() > 0) begin
                item_t      it;
                logic [3:0] got;
                it  = sbq.pop_front();
                got = it.on_pins ? {2'b00, st_err, cmp_err} : reg_rdata;
                n_cmp++;
                if (got !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
                end
            end
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    // expectation for the state after the next rising edge
    task automatic chk(input logic c, input logic s, input logic addr,
                       input logic [3:0] exp, input string tag);
        item_t it;
        reg_addr   = addr;
        it.on_pins = 1'b1;
        it.exp     = {2'b00, s, c};
        it.tag     = {tag, " [pins st,cmp]"};
        sbq.push_back(it);
        it.on_pins = 1'b0;
        it.exp     = exp;
        it.tag     = {tag, " [readback]"};
        sbq.push_back(it);
        step();
    endtask

    task automatic wr(input logic addr, input logic [3:0] data, input logic p);
        reg_wr    = 1'b1;
        reg_addr  = addr;
        reg_wdata = data;
        priv      = p;
        step();
        reg_wr = 1'b0;
        priv   = 1'b1;
    endtask

    localparam logic STAT = 1'b0;
    localparam logic KEY  = 1'b1;

    initial begin
        core_a = 32'h1234_5678;
        core_b = 32'h1234_5678;
        repeat (3) step();
        rst = 1'b0;
        chk(0, 0, STAT, 4'h0, "R12 status after reset");
        chk(0, 0, KEY,  4'h0, "R12 key after reset");

        // normal compare
        chk(0, 0, STAT, 4'h0, "R1 equal buses no error");
        core_b = core_a ^ 32'h8000_0000;
        chk(1, 0, STAT, 4'h1, "R1 top bit mismatch");
        core_b = core_a;
        chk(0, 0, STAT, 4'h1, "R2 flag sticky after agreement");
        core_b = core_a ^ 32'h1;
        chk(1, 0, STAT, 4'h1, "R2 first of two pulses");
        chk(1, 0, STAT, 4'h1, "R2 second of two pulses");
        core_b = core_a;
        chk(0, 0, STAT, 4'h1, "R2 pulse ends");

        // write-one-to-clear
        wr(STAT, 4'h0, 1'b1);
        chk(0, 0, STAT, 4'h1, "R11 writing 0 keeps flag");
        wr(STAT, 4'h1, 1'b1);
        chk(0, 0, STAT, 4'h0, "R11 writing 1 clears flag");

        // unknown key
        wr(KEY, 4'h5, 1'b1);
        chk(0, 0, KEY, 4'h0, "R10 unknown key ignored");

        // privilege
        core_b = core_a ^ 32'h0001_0000;
        chk(1, 0, STAT, 4'h1, "R8 setup flag");
        core_b = core_a;
        wr(STAT, 4'h1, 1'b0);
        chk(0, 0, STAT, 4'h1, "R8 user clear ignored");
        wr(KEY, 4'h9, 1'b0);
        chk(0, 0, KEY, 4'h0, "R8 user key ignored");
        wr(STAT, 4'h1, 1'b1);
        chk(0, 0, STAT, 4'h0, "R11 privileged clear");

        // compare-error forcing
        wr(KEY, 4'h9, 1'b1);
        chk(1, 0, KEY,  4'h0, "R6 forced compare pulse and key back to 0");
        chk(0, 0, STAT, 4'h1, "R6 single pulse and flag set");
        wr(STAT, 4'h1, 1'b1);

        // self-test-error forcing
        wr(KEY, 4'hF, 1'b1);
        chk(0, 1, KEY,  4'h0, "R7 self-test error pulse and key back to 0");
        chk(0, 0, STAT, 4'h0, "R7 compare path untouched");
        core_b = core_a ^ 32'h0000_0100;
        chk(1, 0, STAT, 4'h1, "R7 normal compare resumes");
        core_b = core_a;
        wr(STAT, 4'h1, 1'b1);

        // self-test with diverging cores (must be ignored)
        wr(KEY, 4'h6, 1'b1);
        core_b = core_a ^ 32'h0000_00FF;
        for (int k = 1; k <= 2 * W + 1; k++) begin
            chk(0, 0, STAT, (k == 2 * W + 1) ? 4'h3 : 4'h0, "R3 self-test timing");
        end
        chk(0, 0, STAT, 4'h3, "R4 flag set after self-test, no self-test error");
        core_b = core_a;
        wr(KEY, 4'h0, 1'b1);
        chk(0, 0, STAT, 4'h1, "R5 done hidden outside self-test key");
        wr(STAT, 4'h1, 1'b1);

        // second self-test, then clear its done bit
        wr(KEY, 4'h6, 1'b1);
        for (int k = 0; k < 2 * W + 1; k++) step();
        chk(0, 0, STAT, 4'h3, "R3 second self-test complete");
        wr(STAT, 4'h2, 1'b1);
        chk(0, 0, STAT, 4'h1, "R11 done bit write-one-to-clear");
        wr(KEY, 4'h0, 1'b1);

        // debug halt
        dbg_halt = 1'b1;
        core_b = core_a ^ 32'h0000_0010;
        chk(0, 0, STAT, 4'h1, "R9 no error while halted");
        wr(STAT, 4'h1, 1'b1);
        chk(0, 0, STAT, 4'h1, "R9 status frozen");
        wr(KEY, 4'hF, 1'b1);
        chk(0, 0, KEY, 4'h0, "R9 key write ignored");
        dbg_halt = 1'b0;
        chk(0, 0, STAT, 4'h1, "R9 quiet after halt released");
        rst = 1'b1;
        step();
        rst = 1'b0;
        chk(1, 0, STAT, 4'h1, "R9 reset restores compare");

        step();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule